// File: doc/BRIEF.md
# Dual-Copy Parity Register File with Twin Repair

This block is a register file with one write port and two read ports. It is built from two identical storage banks, and each bank has one write port and one read port. Every write goes to both banks. Read port A is served by bank 0 and read port B by bank 1, so the second copy provides the second read port and also serves as the repair source.

Each stored word carries an even parity bit. Reads are combinational. The parity check runs alongside the data and does not delay it, so a consumer can use the word in the same cycle it reads it. When a check fails, the port raises its error flag and a small repair machine starts. It spends one cycle fetching the word from the twin bank. It then spends one cycle writing that word into the failing bank and pulses a replay strobe in that cycle. After the repair, the consumer repeats its operation and reads clean data. If the twin copy is also corrupt, the machine only reports an uncorrectable error. Rewinding the consumer's pipeline is left to the consumer.

A fault port flips a single stored bit in a chosen bank. It stands in for a particle upset so that the repair path can be exercised.

Top module: `rfpdup_regfile`

## Requirements
- R1: A stored word is W+1 bits wide. Bits W-1..0 hold the data and bit W holds even parity, which is the XOR of the data bits. Flipping only bit W leaves the read data unchanged but makes the read fail its parity check.
- R2: Every accepted write updates the same address in both banks. After a write, both read ports return the written data from that address with no error, and this holds when the two ports read different addresses in the same cycle.
- R3: A read port's error output is high in the same cycle as a read whose stored word fails parity. It is high only while that port's enable is high and the repair machine is idle. An idle machine that sees an error becomes busy at the next clock edge.
- R4: When a single bank is corrupt, busy stays high for exactly two cycles and replay is high only in the second of them. From the following cycle on, the failing port returns the original data with no error.
- R5: A write requested while busy is high is dropped: both banks keep their previous contents.
- R6: When both banks hold a failing word at the failing address, uncorrectable is high during the single busy cycle, replay never rises, and the word still fails parity afterwards on both ports.
- R7: When both ports report an error in the same cycle, bank 0 (port A) is repaired first. Port B's error persists until a second repair that follows.
- R8: With the upset enable high at a clock edge, the stored bit at the given index, address and bank (0 or 1) is inverted. A write to the same bank and address in the same cycle takes precedence over the upset.
- R9: After reset, busy, replay and uncorrectable are low, and every address reads zero with no error on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write data |
| rda_en | input | 1 | Port A read enable |
| rda_addr | input | AW | Port A address (bank 0) |
| rda_data | output | W | Port A data |
| rda_err | output | 1 | Port A parity failure |
| rdb_en | input | 1 | Port B read enable |
| rdb_addr | input | AW | Port B address (bank 1) |
| rdb_data | output | W | Port B data |
| rdb_err | output | 1 | Port B parity failure |
| upset_en | input | 1 | Invert one stored bit |
| upset_bank | input | 1 | Bank receiving the upset |
| upset_addr | input | AW | Address receiving the upset |
| upset_bit | input | BW | Bit index, 0..W |
| busy | output | 1 | Repair in progress |
| replay | output | 1 | Repeat the failed operation |
| uncorrectable | output | 1 | Both copies corrupt |

## Verification
A wrong internal state shows up at the ports within a cycle or two. If a repair writes the wrong bank or the wrong address, the failing port still flags an error in the cycle after busy falls. If the repair machine stalls or loops, busy stays high past its second cycle. A write that slips through while busy is high becomes visible the next time either port reads that address, as data that differs from what the bench expects. The port priority shows up directly: the bench reads which port's flag clears first after a dual failure.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

  localparam int NBANK = 2;

  typedef enum logic [1:0] {
    FIX_IDLE  = 2'd0,
    FIX_FETCH = 2'd1,
    FIX_WRITE = 2'd2
  } fix_state_e;

endpackage

// File: rtl/rfp_bank.sv
module rfp_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W:0]    wword,
  input  logic [AW-1:0] raddr,
  output logic [W:0]    rword,
  input  logic          flip_en,
  input  logic [AW-1:0] flip_addr,
  input  logic [BW-1:0] flip_bit
);

  logic [W:0] mem [DEPTH];

  logic flip_hit_write;
  logic flip_in_range;

  assign flip_hit_write = we && (waddr == flip_addr);
  assign flip_in_range  = (int'(flip_bit) <= W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we) mem[waddr] <= wword;
      if (flip_en && flip_in_range && !flip_hit_write)
        mem[flip_addr][flip_bit] <= ~mem[flip_addr][flip_bit];
    end
  end

  assign rword = mem[raddr];

endmodule

// File: rtl/rfp_repair.sv
module rfp_repair
  import rfp_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_a,
  input  logic          start_b,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [W:0]    good_word,
  output logic          busy,
  output logic          fetching,
  output logic          fix_we,
  output logic          replay,
  output logic          fatal,
  output logic          bad_bank,
  output logic [AW-1:0] fix_addr,
  output logic [W:0]    fix_word
);

  function automatic logic word_bad(input logic [W:0] w);
    return ^w;
  endfunction

  fix_state_e    state;
  logic [W:0]    held;
  logic          good_fails;

  assign good_fails = word_bad(good_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FIX_IDLE;
      held     <= '0;
      bad_bank <= 1'b0;
      fix_addr <= '0;
    end else begin
      case (state)
        FIX_IDLE: begin
          if (start_a) begin
            bad_bank <= 1'b0;
            fix_addr <= addr_a;
            state    <= FIX_FETCH;
          end else if (start_b) begin
            bad_bank <= 1'b1;
            fix_addr <= addr_b;
            state    <= FIX_FETCH;
          end
        end
        FIX_FETCH: begin
          if (good_fails) begin
            state <= FIX_IDLE;
          end else begin
            held  <= good_word;
            state <= FIX_WRITE;
          end
        end
        FIX_WRITE: state <= FIX_IDLE;
        default:   state <= FIX_IDLE;
      endcase
    end
  end

  assign busy     = (state != FIX_IDLE);
  assign fetching = (state == FIX_FETCH);
  assign fix_we   = (state == FIX_WRITE);
  assign replay   = fix_we;
  assign fatal    = fetching && good_fails;
  assign fix_word = held;

endmodule

// File: rtl/rfpdup_regfile.sv
module rfpdup_regfile
  import rfp_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rda_en,
  input  logic [AW-1:0] rda_addr,
  output logic [W-1:0]  rda_data,
  output logic          rda_err,
  input  logic          rdb_en,
  input  logic [AW-1:0] rdb_addr,
  output logic [W-1:0]  rdb_data,
  output logic          rdb_err,
  input  logic          upset_en,
  input  logic          upset_bank,
  input  logic [AW-1:0] upset_addr,
  input  logic [BW-1:0] upset_bit,
  output logic          busy,
  output logic          replay,
  output logic          uncorrectable
);

  function automatic logic [W:0] encode(input logic [W-1:0] d);
    return {^d, d};
  endfunction

  function automatic logic word_bad(input logic [W:0] w);
    return ^w;
  endfunction

  logic          user_wr_taken;
  logic          fetching;
  logic          fix_we;
  logic          bad_bank;
  logic [AW-1:0] fix_addr;
  logic [W:0]    fix_word;
  logic [W:0]    good_word;

  logic [AW-1:0] user_raddr [NBANK];
  logic [AW-1:0] bank_raddr [NBANK];
  logic [W:0]    bank_rword [NBANK];
  logic          bank_we    [NBANK];
  logic          bank_bad   [NBANK];

  assign user_wr_taken = wr_en && !busy;
  assign user_raddr[0] = rda_addr;
  assign user_raddr[1] = rdb_addr;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    logic          is_good_src;
    logic [AW-1:0] waddr_k;
    logic [W:0]    wword_k;

    assign is_good_src   = fetching && (bad_bank != 1'(k));
    assign bank_raddr[k] = is_good_src ? fix_addr : user_raddr[k];
    assign bank_we[k]    = user_wr_taken || (fix_we && (bad_bank == 1'(k)));
    assign waddr_k       = fix_we ? fix_addr : wr_addr;
    assign wword_k       = fix_we ? fix_word : encode(wr_data);
    assign bank_bad[k]   = word_bad(bank_rword[k]);

    rfp_bank #(.W(W), .DEPTH(DEPTH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bank_we[k]),
      .waddr     (waddr_k),
      .wword     (wword_k),
      .raddr     (bank_raddr[k]),
      .rword     (bank_rword[k]),
      .flip_en   (upset_en && (upset_bank == 1'(k))),
      .flip_addr (upset_addr),
      .flip_bit  (upset_bit)
    );
  end

  assign good_word = bad_bank ? bank_rword[0] : bank_rword[1];

  assign rda_data = bank_rword[0][W-1:0];
  assign rdb_data = bank_rword[1][W-1:0];
  assign rda_err  = rda_en && !busy && bank_bad[0];
  assign rdb_err  = rdb_en && !busy && bank_bad[1];

  rfp_repair #(.W(W), .AW(AW)) u_repair (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_a   (rda_err),
    .start_b   (rdb_err),
    .addr_a    (rda_addr),
    .addr_b    (rdb_addr),
    .good_word (good_word),
    .busy      (busy),
    .fetching  (fetching),
    .fix_we    (fix_we),
    .replay    (replay),
    .fatal     (uncorrectable),
    .bad_bank  (bad_bank),
    .fix_addr  (fix_addr),
    .fix_word  (fix_word)
  );

endmodule

// File: rtl/rfp_checker.sv
module rfp_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic replay,
  input logic uncorrectable,
  input logic rda_err,
  input logic rdb_err,
  input logic user_wr_taken,
  input logic fetching
);

  assert_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !user_wr_taken);

  assert_replay_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> $past(fetching));

  assert_replay_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> !replay);

  assert_busy_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  assert_error_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (rda_err || rdb_err)) |=> busy);

  assert_fatal_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |=> (!busy && !replay));

  assert_fatal_no_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(uncorrectable && replay));

endmodule

bind rfpdup_regfile rfp_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .replay        (replay),
  .uncorrectable (uncorrectable),
  .rda_err       (rda_err),
  .rdb_err       (rdb_err),
  .user_wr_taken (user_wr_taken),
  .fetching      (fetching)
);

// File: tb/rfpdup_regfile_test.sv
module rfpdup_regfile_test;

  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int BW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          rda_en = 1'b0;
  logic [AW-1:0] rda_addr = '0;
  logic [W-1:0]  rda_data;
  logic          rda_err;
  logic          rdb_en = 1'b0;
  logic [AW-1:0] rdb_addr = '0;
  logic [W-1:0]  rdb_data;
  logic          rdb_err;
  logic          upset_en = 1'b0;
  logic          upset_bank = 1'b0;
  logic [AW-1:0] upset_addr = '0;
  logic [BW-1:0] upset_bit = '0;
  logic          busy;
  logic          replay;
  logic          uncorrectable;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] model [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  rfpdup_regfile #(.W(W), .DEPTH(DEPTH)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic upset(input bit bank, input int a, input int b);
    upset_en = 1'b1; upset_bank = bank; upset_addr = AW'(a); upset_bit = BW'(b);
    tick();
    upset_en = 1'b0;
  endtask

  function automatic logic [W-1:0] pat(input int a);
    return W'(a * 16'h1357) ^ 16'h0F0F;
  endfunction

  task automatic t_reset();
    rda_en = 1'b1; rda_addr = 4'd0; rdb_en = 1'b1; rdb_addr = 4'd15;
    #1;
    chk(busy == 0 && replay == 0 && uncorrectable == 0, "R9 status idle", {busy, replay, uncorrectable}, 0);
    chk(rda_data == 0 && rda_err == 0, "R9 port A zero", {rda_err, rda_data}, 0);
    chk(rdb_data == 0 && rdb_err == 0, "R9 port B zero", {rdb_err, rdb_data}, 0);
    rda_en = 1'b0; rdb_en = 1'b0;
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a));
    for (int a = 0; a < DEPTH; a++) begin
      rda_en = 1'b1; rda_addr = AW'(a); rdb_en = 1'b1; rdb_addr = AW'(DEPTH - 1 - a);
      #1;
      chk(rda_data == model[a] && !rda_err, "R2 port A read", {rda_err, rda_data}, model[a]);
      chk(rdb_data == model[DEPTH-1-a] && !rdb_err, "R2 port B read", {rdb_err, rdb_data}, model[DEPTH-1-a]);
    end
    rda_en = 1'b0; rdb_en = 1'b0;
  endtask

  task automatic t_single();
    wr(5, 16'hA5C3);
    upset(1'b0, 5, 2);
    rda_en = 1'b1; rda_addr = 4'd5;
    #1;
    chk(rda_err == 1, "R3 error same cycle", rda_err, 1);
    chk(rda_data == (16'hA5C3 ^ 16'h0004), "R8 flipped bit seen", rda_data, 16'hA5C3 ^ 16'h0004);
    tick();
    chk(busy == 1 && replay == 0, "R4 fetch cycle", {busy, replay}, 2);
    tick();
    chk(busy == 1 && replay == 1, "R4 write cycle replay", {busy, replay}, 3);
    tick();
    chk(busy == 0 && replay == 0, "R4 idle after repair", {busy, replay}, 0);
    chk(rda_err == 0 && rda_data == 16'hA5C3, "R4 repaired data", {rda_err, rda_data}, 16'hA5C3);
    rda_en = 1'b0;
  endtask

  task automatic t_parity_bit();
    wr(11, 16'h0001);
    upset(1'b1, 11, W);
    rdb_en = 1'b1; rdb_addr = 4'd11;
    #1;
    chk(rdb_err == 1, "R1 parity bit flip detected", rdb_err, 1);
    chk(rdb_data == 16'h0001, "R1 data intact", rdb_data, 16'h0001);
    tick(); tick(); tick();
    chk(rdb_err == 0 && rdb_data == 16'h0001, "R1 parity repaired", {rdb_err, rdb_data}, 16'h0001);
    rdb_en = 1'b0;
  endtask

  task automatic t_enable_gate();
    wr(8, 16'h3C3C);
    upset(1'b0, 8, 9);
    rda_en = 1'b0; rda_addr = 4'd8;
    #1;
    chk(rda_err == 0, "R3 no error when disabled", rda_err, 0);
    tick();
    chk(busy == 0, "R3 no repair when disabled", busy, 0);
    rda_en = 1'b1;
    #1;
    chk(rda_err == 1, "R3 error when enabled", rda_err, 1);
    tick(); tick(); tick();
    chk(rda_err == 0 && rda_data == 16'h3C3C, "R3 repaired after enable", {rda_err, rda_data}, 16'h3C3C);
    rda_en = 1'b0;
  endtask

  task automatic t_write_blocked();
    wr(2, 16'h1111);
    wr(6, 16'h6666);
    upset(1'b0, 6, 0);
    rda_en = 1'b1; rda_addr = 4'd6;
    tick();
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'h2222;
    tick(); tick();
    wr_en = 1'b0;
    rda_en = 1'b1; rda_addr = 4'd2; rdb_en = 1'b1; rdb_addr = 4'd2;
    #1;
    chk(rda_data == 16'h1111 && !rda_err, "R5 bank0 kept", {rda_err, rda_data}, 16'h1111);
    chk(rdb_data == 16'h1111 && !rdb_err, "R5 bank1 kept", {rdb_err, rdb_data}, 16'h1111);
    rda_en = 1'b0; rdb_en = 1'b0;
  endtask

  task automatic t_double();
    wr(3, 16'hBEEF);
    upset(1'b0, 3, 1);
    upset(1'b1, 3, 5);
    rda_en = 1'b1; rda_addr = 4'd3;
    tick();
    chk(busy == 1 && uncorrectable == 1 && replay == 0, "R6 uncorrectable flagged", {busy, uncorrectable, replay}, 6);
    rda_en = 1'b0;
    tick();
    chk(busy == 0 && replay == 0 && uncorrectable == 0, "R6 no repair", {busy, replay, uncorrectable}, 0);
    rda_en = 1'b1; rdb_en = 1'b1; rdb_addr = 4'd3;
    #1;
    chk(rda_err == 1 && rdb_err == 1, "R6 still corrupt", {rda_err, rdb_err}, 3);
    rda_en = 1'b0; rdb_en = 1'b0;
    wr(3, 16'hBEEF);
    rda_en = 1'b1; rdb_en = 1'b1;
    #1;
    chk(!rda_err && !rdb_err && rda_data == 16'hBEEF, "R2 rewrite clears", {rda_err, rdb_err, rda_data}, 16'hBEEF);
    rda_en = 1'b0; rdb_en = 1'b0;
  endtask

  task automatic t_both();
    wr(7, 16'h7777);
    wr(9, 16'h9999);
    upset(1'b0, 7, 0);
    upset(1'b1, 9, 3);
    rda_en = 1'b1; rda_addr = 4'd7; rdb_en = 1'b1; rdb_addr = 4'd9;
    #1;
    chk(rda_err && rdb_err, "R7 both flagged", {rda_err, rdb_err}, 3);
    tick(); tick(); tick();
    chk(rda_err == 0 && rdb_err == 1, "R7 port A first", {rda_err, rdb_err}, 1);
    tick(); tick(); tick();
    chk(rdb_err == 0 && rdb_data == 16'h9999 && rda_data == 16'h7777, "R7 port B repaired", {rdb_err, rdb_data}, 16'h9999);
    rda_en = 1'b0; rdb_en = 1'b0;
  endtask

  task automatic t_upset_vs_write();
    wr(12, 16'h00F0);
    upset_en = 1'b1; upset_bank = 1'b0; upset_addr = 4'd12; upset_bit = 5'd4;
    wr(12, 16'h0F00);
    upset_en = 1'b0;
    rda_en = 1'b1; rda_addr = 4'd12;
    #1;
    chk(rda_data == 16'h0F00 && !rda_err, "R8 write wins over upset", {rda_err, rda_data}, 16'h0F00);
    rda_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    #(CLK_P * 3);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fill();
    t_single();
    t_parity_bit();
    t_enable_gate();
    t_write_blocked();
    t_double();
    t_both();
    t_upset_vs_write();
    tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule